// File: doc/BRIEF.md
# Missing-Edge Clock Loss Monitor

This block decides whether a slow, asynchronous clock is still alive. A fast system clock samples both that monitored clock and a feedback clock. The block counts rising edges of the feedback clock that arrive after the most recent rising edge of the monitored clock. When this count reaches the miss limit, a bad-clock alarm is raised. The first monitored edge that follows clears the alarm at once. Loss is therefore judged in units of feedback periods rather than by a free-running timer.

Two feedback sources are wired in. They stand for the feedback of a wide-bandwidth loop and of a narrow-bandwidth loop. A mode input chooses which of the two is counted. A monitored reference can pass through a divide-by-P stage before the comparison, and a synchronous enable switches that stage in or out. A parameter builds the variant used for a crystal input. That variant always counts the wide-loop feedback and ignores both the lower feedback input and the mode input.

The same alarm drives two outputs, one standing for a pin and one for a status bit. The current miss count is also available as an output.

Top module: `clk_loss_monitor`

## Requirements
- R1: After reset the alarm and status outputs are 0 and the miss count is 0.
- R2: Each rising edge on the selected feedback raises the miss count by one, and the count saturates at MISS_LIMIT (default 3).
- R3: The alarm becomes 1 on the MISS_LIMIT-th selected feedback edge when no monitored edge occurs in between. It stays 0 before that edge.
- R4: A single counted monitored edge sets the alarm to 0 and the miss count to 0.
- R5: When low_bw_i is 0, only fb_upper_i edges are counted. When low_bw_i is 1, only fb_lower_i edges are counted. Edges on the unselected feedback leave the count unchanged.
- R6: When prediv_en_i is 1, only every PREDIV-th monitored rising edge (default 3) is counted as a monitored edge, starting from the first edge after reset. When prediv_en_i is 0, every monitored edge counts and the divider phase holds its value.
- R7: When a counted monitored edge and a selected feedback edge occur in the same system cycle, the monitored edge wins and the count becomes 0.
- R8: stat_bad_o equals alarm_o at all times.
- R9: Falling edges on any clock input have no effect on the count or the alarm.
- R10: With USE_LOWER_FB = 0 (the crystal variant), only fb_upper_i is counted, whatever the values of low_bw_i and fb_lower_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast system clock |
| rst_ni | input | 1 | Active-low reset |
| mon_clk_i | input | 1 | Monitored clock (asynchronous) |
| fb_upper_i | input | 1 | Wide-loop feedback clock (asynchronous) |
| fb_lower_i | input | 1 | Narrow-loop feedback clock (asynchronous) |
| low_bw_i | input | 1 | 1 selects the narrow-loop feedback |
| prediv_en_i | input | 1 | Routes the monitored edges through the divide-by-P stage |
| alarm_o | output | 1 | Bad-clock alarm, pin copy |
| stat_bad_o | output | 1 | Bad-clock alarm, status copy |
| miss_cnt_o | output | CNT_W | Feedback edges seen since the last counted monitored edge |

## Verification
Directed runs of one, two, three and four feedback edges separate a count that increments from one that saturates and from an alarm that fires early or late. Edges on the unselected feedback, falling edges and mode changes show whether the source mux and the edge detectors pick up the wrong transition. Monitored edges with the divider on show whether the divider phase is correct: the alarm must survive the first two edges and clear on the third. A simultaneous monitored and feedback edge exposes the priority between the two. Random mixes of edges, mode and divider enable are then checked against a bench model, on the default instance and on a crystal-variant instance side by side.

// File: rtl/clm_pkg.sv
package clm_pkg;

   // Edge events presented to the miss counter in one system cycle.
   typedef struct packed {
      logic mon;
      logic fb;
   } clm_evt_t;

   // Index of each raw clock inside the synchronizer bank.
   localparam int IDX_MON = 0;
   localparam int IDX_UP  = 1;
   localparam int IDX_LO  = 2;
   localparam int N_CLKS  = 3;

endpackage

// File: rtl/clm_edge_sync.sv
module clm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);

   initial begin
      assert (STAGES >= 2) else $error("clm_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sh_q   <= '0;
         last_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], async_i};
         last_q <= sh_q[STAGES-1];
      end
   end

   assign rise_o = sh_q[STAGES-1] & ~last_q;

   // R9: a detected rising edge is a single-cycle pulse
   p_single_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);

endmodule

// File: rtl/clm_prediv.sv
module clm_prediv #(
   parameter int PREDIV = 3
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic edge_i,
   output logic edge_o
);

   initial begin
      assert (PREDIV >= 1) else $error("clm_prediv: PREDIV must be at least 1");
   end

   generate
      if (PREDIV == 1) begin : g_bypass
         assign edge_o = edge_i;
         logic unused_en;
         assign unused_en = en_i;
      end else begin : g_div
         localparam int DW = $clog2(PREDIV);
         localparam logic [DW-1:0] LAST = DW'(PREDIV - 1);
         logic [DW-1:0] ph_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               ph_q <= '0;
            end else if (en_i && edge_i) begin
               ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
            end
         end

         assign edge_o = edge_i & (~en_i | (ph_q == LAST));

         // R6: the divider phase holds while the divider is off
         p_phase_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_i |=> $stable(ph_q));
         // R6: the phase never leaves its range
         p_phase_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            ph_q <= LAST);
      end
   endgenerate

   // R6: the stage passes no edge that it did not receive
   p_no_spurious_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_o |-> edge_i);

endmodule

// File: rtl/clm_miss_counter.sv
module clm_miss_counter
   import clm_pkg::*;
#(
   parameter int MISS_LIMIT = 3,
   localparam int CNT_W = $clog2(MISS_LIMIT + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  clm_evt_t         evt_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             alarm_o
);

   initial begin
      assert (MISS_LIMIT >= 1) else $error("clm_miss_counter: MISS_LIMIT must be at least 1");
   end

   localparam logic [CNT_W-1:0] LIM = CNT_W'(MISS_LIMIT);

   logic [CNT_W-1:0] cnt_q;
   logic             alarm_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         alarm_q <= 1'b0;
      end else if (evt_i.mon) begin
         cnt_q   <= '0;
         alarm_q <= 1'b0;
      end else if (evt_i.fb && (cnt_q != LIM)) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == LIM - 1'b1) begin
            alarm_q <= 1'b1;
         end
      end
   end

   assign cnt_o   = cnt_q;
   assign alarm_o = alarm_q;

   // R2: the count never exceeds the limit
   p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LIM);
   // R2: a lone feedback edge below the limit increments the count
   p_increment_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!evt_i.mon && evt_i.fb && cnt_q < LIM) |=> cnt_q == $past(cnt_q) + 1'b1);
   // R3: the alarm is raised exactly when the limit is reached
   p_alarm_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alarm_q == (cnt_q == LIM));
   // R4, R7: a monitored edge clears everything, even alongside a feedback edge
   p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i.mon |=> (!alarm_q && cnt_q == '0));
   // R5: no event, no change
   p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!evt_i.mon && !evt_i.fb) |=> ($stable(cnt_q) && $stable(alarm_q)));

endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor
   import clm_pkg::*;
#(
   parameter int MISS_LIMIT   = 3,
   parameter int PREDIV       = 3,
   parameter int SYNC_STAGES  = 2,
   parameter bit USE_LOWER_FB = 1'b1,
   localparam int CNT_W = $clog2(MISS_LIMIT + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             mon_clk_i,
   input  logic             fb_upper_i,
   input  logic             fb_lower_i,
   input  logic             low_bw_i,
   input  logic             prediv_en_i,
   output logic             alarm_o,
   output logic             stat_bad_o,
   output logic [CNT_W-1:0] miss_cnt_o
);

   logic [N_CLKS-1:0] raw;
   logic [N_CLKS-1:0] rise;
   logic              mon_ev;
   logic              fb_ev;
   clm_evt_t          evt;
   logic              alarm;

   assign raw[IDX_MON] = mon_clk_i;
   assign raw[IDX_UP]  = fb_upper_i;
   assign raw[IDX_LO]  = fb_lower_i;

   generate
      for (genvar i = 0; i < N_CLKS; i++) begin : g_sync
         clm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .async_i(raw[i]),
            .rise_o (rise[i])
         );
      end
   endgenerate

   clm_prediv #(.PREDIV(PREDIV)) u_prediv (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (prediv_en_i),
      .edge_i(rise[IDX_MON]),
      .edge_o(mon_ev)
   );

   generate
      if (USE_LOWER_FB) begin : g_fb_mux
         assign fb_ev = low_bw_i ? rise[IDX_LO] : rise[IDX_UP];
      end else begin : g_fb_upper
         assign fb_ev = rise[IDX_UP];
         logic unused_fb;
         assign unused_fb = rise[IDX_LO] ^ low_bw_i;
      end
   endgenerate

   assign evt.mon = mon_ev;
   assign evt.fb  = fb_ev;

   clm_miss_counter #(.MISS_LIMIT(MISS_LIMIT)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .evt_i  (evt),
      .cnt_o  (miss_cnt_o),
      .alarm_o(alarm)
   );

   assign alarm_o    = alarm;
   assign stat_bad_o = alarm;

   // R5: an edge on the unselected feedback alone does not move the count
   p_unselected_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!mon_ev && !(low_bw_i ? rise[IDX_LO] : rise[IDX_UP]) && USE_LOWER_FB)
         |=> $stable(miss_cnt_o));
   // R10: in the crystal variant the lower feedback edge alone does nothing
   p_xtal_upper_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!USE_LOWER_FB && !mon_ev && !rise[IDX_UP]) |=> $stable(miss_cnt_o));

endmodule

// File: tb/clk_loss_monitor_test.sv
module clk_loss_monitor_test;

   localparam int LIM = 3;
   localparam int P   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mon = 1'b0, up = 1'b0, lo = 1'b0, lowbw = 1'b0, pden = 1'b0;
   logic al_a, st_a, al_x, st_x;
   logic [1:0] cnt_a, cnt_x;

   int checks = 0;
   int errors = 0;
   int m_div = 0;
   int m_cnt [2];
   int m_al  [2];

   always #2 clk = ~clk;

   clk_loss_monitor #(.MISS_LIMIT(LIM), .PREDIV(P), .USE_LOWER_FB(1'b1)) uut (
      .clk_i(clk), .rst_ni(rst_n), .mon_clk_i(mon), .fb_upper_i(up), .fb_lower_i(lo),
      .low_bw_i(lowbw), .prediv_en_i(pden), .alarm_o(al_a), .stat_bad_o(st_a),
      .miss_cnt_o(cnt_a));

   clk_loss_monitor #(.MISS_LIMIT(LIM), .PREDIV(P), .USE_LOWER_FB(1'b0)) uut_xtal (
      .clk_i(clk), .rst_ni(rst_n), .mon_clk_i(mon), .fb_upper_i(up), .fb_lower_i(lo),
      .low_bw_i(lowbw), .prediv_en_i(1'b0), .alarm_o(al_x), .stat_bad_o(st_x),
      .miss_cnt_o(cnt_x));

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: act=%0d exp=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " count"}, int'(cnt_a), m_cnt[0]);
      chk({tag, " alarm"}, int'(al_a), m_al[0]);
      chk({tag, " R8 status mirror"}, int'(st_a), m_al[0]);
      chk({tag, " R10 xtal count"}, int'(cnt_x), m_cnt[1]);
      chk({tag, " R10 xtal alarm"}, int'(al_x), m_al[1]);
      chk({tag, " R8 xtal mirror"}, int'(st_x), m_al[1]);
   endtask

   function automatic void upd(input int k, input bit mev, input bit fev);
      if (mev) begin
         m_cnt[k] = 0;
         m_al[k]  = 0;
      end else if (fev && m_cnt[k] < LIM) begin
         m_cnt[k]++;
         if (m_cnt[k] == LIM) m_al[k] = 1;
      end
   endfunction

   function automatic void model_rise(input bit m, input bit u, input bit l);
      bit mev;
      mev = m && (!pden || m_div == P - 1);
      if (pden && m) m_div = (m_div == P - 1) ? 0 : m_div + 1;
      upd(0, mev, lowbw ? l : u);
      upd(1, m, u);
   endfunction

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Raise the chosen clocks together, check, drop them, check again (R9).
   task automatic pulse(input bit m, input bit u, input bit l, input string tag);
      @(negedge clk);
      mon = m; up = u; lo = l;
      model_rise(m, u, l);
      wait_cyc(5);
      check_all(tag);
      mon = 1'b0; up = 1'b0; lo = 1'b0;
      wait_cyc(5);
      check_all({tag, " R9 falling"});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL WDOG: act=running exp=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_cnt[0] = 0; m_cnt[1] = 0; m_al[0] = 0; m_al[1] = 0;
      wait_cyc(3);
      check_all("R1 reset");
      rst_n = 1'b1;
      wait_cyc(3);
      check_all("R1 after release");

      // R2, R3: upper feedback, wide mode
      pulse(0, 1, 0, "R2 first");
      pulse(0, 1, 0, "R2 second");
      chk("R3 no early alarm", int'(al_a), 0);
      pulse(0, 1, 0, "R3 third");
      chk("R3 alarm raised", int'(al_a), 1);
      pulse(0, 1, 0, "R2 saturate");
      chk("R2 saturated", int'(cnt_a), LIM);
      // R4: one monitored edge clears
      pulse(1, 0, 0, "R4 clear");
      chk("R4 alarm cleared", int'(al_a), 0);
      // R5: unselected lower feedback ignored in wide mode
      pulse(0, 0, 1, "R5 lower ignored");
      chk("R5 count held", int'(cnt_a), 0);
      // R5, R10: narrow mode counts lower; crystal variant does not
      lowbw = 1'b1;
      pulse(0, 0, 1, "R5 lower counted");
      chk("R10 xtal ignores lower", int'(cnt_x), 0);
      pulse(0, 1, 0, "R5 upper ignored");
      pulse(0, 0, 1, "R5 lower 2");
      pulse(0, 0, 1, "R5 lower 3");
      chk("R5 alarm via lower", int'(al_a), 1);
      lowbw = 1'b0;
      // R6: divider passes only every third monitored edge
      pden = 1'b1;
      pulse(1, 0, 0, "R6 div edge 1");
      chk("R6 alarm survives edge 1", int'(al_a), 1);
      pulse(1, 0, 0, "R6 div edge 2");
      chk("R6 alarm survives edge 2", int'(al_a), 1);
      pulse(1, 0, 0, "R6 div edge 3");
      chk("R6 alarm cleared by edge 3", int'(al_a), 0);
      pden = 1'b0;
      // R7: simultaneous monitored and feedback edge
      pulse(0, 1, 0, "R7 prep");
      pulse(1, 1, 0, "R7 simultaneous");
      chk("R7 monitored wins", int'(cnt_a), 0);

      // Random mix against the model
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 400; i++) begin
         int r;
         r = int'($urandom_range(0, 15));
         @(negedge clk);
         if (r == 0) lowbw = ~lowbw;
         if (r == 1) pden = ~pden;
         pulse(bit'($urandom_range(0, 3) == 0), bit'($urandom_range(0, 1)),
               bit'($urandom_range(0, 1)), "RND");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule